// File: doc/BRIEF.md
# Set-Associative Cache Tag Controller

This block holds the tag, valid and dirty bookkeeping for a first-level cache with a configurable set count and associativity. A client presents one request at a time: a physical address and a write flag. The flag is driven high for stores and for atomic read-modify-write operations. The block breaks the address into tag, set index and byte offset. It compares the request tag against every way of the indexed set and reports one of four outcomes: hit, fill of an empty way, clean eviction, or dirty eviction. It then updates the stored state to match.

Victim choice is delegated. When a miss finds the set full, the block replaces the way given on `victim_way`, which an external replacement-policy unit drives. Every serviced request then sends that unit a way-touched notice carrying the way and the set. The block also accepts two whole-array commands. Flush drops every dirty bit. Invalidate drops every valid bit. Each takes one cycle, and requests are held off during that cycle. Line data, refill and writeback traffic are handled elsewhere. The old tag of an evicted line is reported so that the writeback address can be rebuilt.

Top module: `cache_tag_ctrl`

## Requirements
- R1: The request tag is the top TAG_W bits of `req_addr`. The set index is the SET_W = log2(SETS) bits directly below it, at bit position OFF_W = ADDR_W - TAG_W - SET_W. The low OFF_W offset bits do not affect the outcome. Defaults: 64 sets, 4 ways, 56-bit address, 44-bit tag.
- R2: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. On the following cycle, and only then, `rsp_valid` and `touch_valid` are high for one cycle. In that cycle `touch_way` equals `rsp_way` and `touch_set` is the request's set index.
- R3: If a valid way of the indexed set holds the request tag, the outcome is hit: `rsp_code` = 2'b00 and `rsp_way` is that way. A write hit sets that line's dirty bit. A read hit leaves it unchanged.
- R4: On a miss where some way of the set is invalid, the lowest-numbered invalid way is filled. The outcome is `rsp_code` = 2'b01.
- R5: On a miss with all ways valid, the way on `victim_way` (sampled at acceptance) is replaced. `rsp_old_tag` carries the tag it held. `rsp_code` is 2'b11 if that line was dirty and 2'b10 if it was clean.
- R6: A filled or replaced line becomes valid with the new tag, and its dirty bit equals the request's write flag.
- R7: `cmd_flush` clears the dirty bit of every line in every set and leaves valid bits and tags unchanged.
- R8: `cmd_inval` clears the valid bit of every line, so the next access to any previously held tag misses.
- R9: In a cycle where `cmd_flush` or `cmd_inval` is high, `req_ready` is low. A request presented in that cycle is not accepted and produces no response.
- R10: A synchronous `rst` clears every valid and dirty bit. After reset `rsp_valid` is low and `req_ready` is high.
- R11: Lines in different sets are independent. Filling a way in one set does not change the state of any other set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_addr | input | ADDR_W | Physical address of the request |
| req_write | input | 1 | Store or atomic access (marks line dirty) |
| victim_way | input | WAY_W | Way picked by the replacement policy for the request's set |
| cmd_flush | input | 1 | Clear all dirty bits this cycle |
| cmd_inval | input | 1 | Clear all valid bits this cycle |
| rsp_valid | output | 1 | Outcome strobe, one cycle after acceptance |
| rsp_code | output | 2 | 00 hit, 01 fill, 10 clean eviction, 11 dirty eviction |
| rsp_way | output | WAY_W | Way that hit, was filled or was replaced |
| rsp_old_tag | output | TAG_W | Tag held by the way before this request |
| touch_valid | output | 1 | Way-touched notice to the replacement policy |
| touch_way | output | WAY_W | Way that was touched |
| touch_set | output | SET_W | Set that was touched |

## Verification
The hardest case to reach from the ports is a dirty eviction whose dirty bit came from a later write hit rather than from the fill. A second hard case is a line that survives a flush but returns as a clean eviction. Both need a set to be filled to capacity first, and then a chosen way to be pushed out. The stimulus fills one set across all four ways and steers replacement through the `victim_way` input. It mixes read fills, write fills and write hits, so that each eviction's clean or dirty code and old tag follow from a known history. Invalidate is checked through where the next access lands, since a hit becomes a fill into way 0.

// File: rtl/cache_tag_pkg.sv
package cache_tag_pkg;

  // Outcome codes reported on rsp_code
  typedef enum logic [1:0] {
    OC_HIT   = 2'b00,
    OC_FILL  = 2'b01,
    OC_CLEAN = 2'b10,
    OC_DIRTY = 2'b11
  } outcome_e;

endpackage

// File: rtl/cache_tag_match.sv
module cache_tag_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 44,
  parameter int WAY_W = 2
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              look_en,
  input  logic [WAYS-1:0][TAG_W-1:0]        row_tags,
  input  logic [WAYS-1:0]                   row_valid,
  input  logic [TAG_W-1:0]                  look_tag,
  output logic [WAYS-1:0]                   hit_vec,
  output logic                              hit_any,
  output logic [WAY_W-1:0]                  hit_way
);

  // one comparator per way
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hit_vec[w] = row_valid[w] && (row_tags[w] == look_tag);
  end

  assign hit_any = |hit_vec;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) hit_way = WAY_W'(w);
    end
  end

  // R3: a tag is never held by two valid ways of the same set
  assert_single_match_R3: assert property (@(posedge clk) disable iff (rst)
    look_en |-> $onehot0(hit_vec));

endmodule

// File: rtl/cache_way_pick.sv
module cache_way_pick
  import cache_tag_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int WAY_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pick_en,
  input  logic [WAYS-1:0]    row_valid,
  input  logic [WAYS-1:0]    row_dirty,
  input  logic               hit_any,
  input  logic [WAY_W-1:0]   hit_way,
  input  logic [WAY_W-1:0]   policy_way,
  output logic [WAY_W-1:0]   sel_way,
  output outcome_e           outcome
);

  logic             free_any;
  logic [WAY_W-1:0] free_way;

  // lowest-numbered invalid way: scan downward so the lowest wins
  always_comb begin
    free_any = 1'b0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!row_valid[w]) begin
        free_any = 1'b1;
        free_way = WAY_W'(w);
      end
    end
  end

  always_comb begin
    if (hit_any) begin
      sel_way = hit_way;
      outcome = OC_HIT;
    end else if (free_any) begin
      sel_way = free_way;
      outcome = OC_FILL;
    end else begin
      sel_way = policy_way;
      outcome = row_dirty[policy_way] ? OC_DIRTY : OC_CLEAN;
    end
  end

  // R4: a fill always lands on a way that was empty
  assert_fill_targets_empty_R4: assert property (@(posedge clk) disable iff (rst)
    (pick_en && outcome == OC_FILL) |-> !row_valid[sel_way]);

  // R5: an eviction only happens in a full set
  assert_evict_only_when_full_R5: assert property (@(posedge clk) disable iff (rst)
    (pick_en && (outcome == OC_CLEAN || outcome == OC_DIRTY)) |-> (&row_valid));

endmodule

// File: rtl/cache_tag_ctrl.sv
module cache_tag_ctrl
  import cache_tag_pkg::*;
#(
  parameter int SETS   = 64,
  parameter int WAYS   = 4,
  parameter int ADDR_W = 56,
  parameter int TAG_W  = 44,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int OFF_W = ADDR_W - TAG_W - SET_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [WAY_W-1:0]  victim_way,
  input  logic              cmd_flush,
  input  logic              cmd_inval,
  output logic              rsp_valid,
  output logic [1:0]        rsp_code,
  output logic [WAY_W-1:0]  rsp_way,
  output logic [TAG_W-1:0]  rsp_old_tag,
  output logic              touch_valid,
  output logic [WAY_W-1:0]  touch_way,
  output logic [SET_W-1:0]  touch_set
);

  // address field extraction
  function automatic logic [TAG_W-1:0] addr_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [SET_W-1:0] addr_set(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: SET_W];
  endfunction

  // state arrays
  logic [WAYS-1:0][TAG_W-1:0] tag_q   [SETS];
  logic [WAYS-1:0]            valid_q [SETS];
  logic [WAYS-1:0]            dirty_q [SETS];

  // named internal events
  logic                       any_cmd;
  logic                       accept;
  logic [TAG_W-1:0]           cur_tag;
  logic [SET_W-1:0]           cur_set;
  logic [WAYS-1:0][TAG_W-1:0] row_tags;
  logic [WAYS-1:0]            row_valid;
  logic [WAYS-1:0]            row_dirty;
  logic [WAYS-1:0]            hit_vec;
  logic                       hit_any;
  logic [WAY_W-1:0]           hit_way;
  logic [WAY_W-1:0]           sel_way;
  outcome_e                   outcome;
  logic                       new_dirty;

  assign any_cmd   = cmd_flush | cmd_inval;
  assign req_ready = !any_cmd;
  assign accept    = req_valid && req_ready;
  assign cur_tag   = addr_tag(req_addr);
  assign cur_set   = addr_set(req_addr);
  assign row_tags  = tag_q[cur_set];
  assign row_valid = valid_q[cur_set];
  assign row_dirty = dirty_q[cur_set];
  assign new_dirty = hit_any ? (row_dirty[sel_way] | req_write) : req_write;

  cache_tag_match #(
    .WAYS  (WAYS),
    .TAG_W (TAG_W),
    .WAY_W (WAY_W)
  ) u_match (
    .clk       (clk),
    .rst       (rst),
    .look_en   (accept),
    .row_tags  (row_tags),
    .row_valid (row_valid),
    .look_tag  (cur_tag),
    .hit_vec   (hit_vec),
    .hit_any   (hit_any),
    .hit_way   (hit_way)
  );

  cache_way_pick #(
    .WAYS  (WAYS),
    .WAY_W (WAY_W)
  ) u_pick (
    .clk        (clk),
    .rst        (rst),
    .pick_en    (accept),
    .row_valid  (row_valid),
    .row_dirty  (row_dirty),
    .hit_any    (hit_any),
    .hit_way    (hit_way),
    .policy_way (victim_way),
    .sel_way    (sel_way),
    .outcome    (outcome)
  );

  // valid and dirty state
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
      end
    end else begin
      if (cmd_flush) begin
        for (int s = 0; s < SETS; s++) dirty_q[s] <= '0;
      end
      if (cmd_inval) begin
        for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
      end
      if (accept) begin
        valid_q[cur_set][sel_way] <= 1'b1;
        dirty_q[cur_set][sel_way] <= new_dirty;
      end
    end
  end

  // tags need no reset: they are qualified by valid
  always_ff @(posedge clk) begin
    if (accept && !hit_any) tag_q[cur_set][sel_way] <= cur_tag;
  end

  // response and replacement notice
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      touch_valid <= 1'b0;
      rsp_code    <= '0;
      rsp_way     <= '0;
      rsp_old_tag <= '0;
      touch_way   <= '0;
      touch_set   <= '0;
    end else begin
      rsp_valid   <= accept;
      touch_valid <= accept;
      if (accept) begin
        rsp_code    <= outcome;
        rsp_way     <= sel_way;
        rsp_old_tag <= row_tags[sel_way];
        touch_way   <= sel_way;
        touch_set   <= cur_set;
      end
    end
  end

  // R2: a strobe appears only after an accepted request
  assert_strobe_after_accept_R2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid && !cmd_flush && !cmd_inval));

  // R7: after a flush the set being looked at holds no dirty line
  assert_flush_clears_dirty_R7: assert property (@(posedge clk) disable iff (rst)
    $past(cmd_flush) |-> (dirty_q[cur_set] == '0));

  // R8: after an invalidate the set being looked at holds no valid line
  assert_inval_clears_valid_R8: assert property (@(posedge clk) disable iff (rst)
    $past(cmd_inval) |-> (valid_q[cur_set] == '0));

  // R5: a dirty eviction reports a line that was resident
  assert_dirty_evict_had_line_R5: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_code == OC_DIRTY) |-> $past(&row_valid));

endmodule

// File: tb/cache_tag_ctrl_test.sv
module cache_tag_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int SETS   = 64;
  localparam int WAYS   = 4;
  localparam int ADDR_W = 56;
  localparam int TAG_W  = 44;
  localparam int SET_W  = 6;
  localparam int WAY_W  = 2;
  localparam int OFF_W  = ADDR_W - TAG_W - SET_W;

  typedef struct packed {
    logic       wr;
    logic [7:0] tag;
    logic [5:0] set;
    logic [1:0] vic;
    logic [1:0] code;
    logic [1:0] way;
    logic [7:0] old;
    logic       chk_old;
  } vec_t;

  // sequence on set 5 (plus one access to set 6); victim matters only when full
  localparam int NVEC = 12;
  localparam vec_t TBL [NVEC] = '{
    '{1'b0, 8'hA1, 6'd5, 2'd0, 2'b01, 2'd0, 8'h00, 1'b0},  // R4 fill way0
    '{1'b1, 8'hB2, 6'd5, 2'd0, 2'b01, 2'd1, 8'h00, 1'b0},  // R4/R6 write fill way1
    '{1'b0, 8'hA1, 6'd5, 2'd3, 2'b00, 2'd0, 8'h00, 1'b0},  // R3 read hit
    '{1'b1, 8'hA1, 6'd5, 2'd3, 2'b00, 2'd0, 8'h00, 1'b0},  // R3 write hit -> dirty
    '{1'b0, 8'hC3, 6'd5, 2'd0, 2'b01, 2'd2, 8'h00, 1'b0},  // R4 fill way2
    '{1'b0, 8'hD4, 6'd5, 2'd0, 2'b01, 2'd3, 8'h00, 1'b0},  // R4 fill way3
    '{1'b0, 8'hE5, 6'd5, 2'd0, 2'b11, 2'd0, 8'hA1, 1'b1},  // R5 dirty via write hit
    '{1'b0, 8'hF6, 6'd5, 2'd2, 2'b10, 2'd2, 8'hC3, 1'b1},  // R5 clean eviction
    '{1'b0, 8'hB2, 6'd5, 2'd0, 2'b00, 2'd1, 8'h00, 1'b0},  // R3 hit way1
    '{1'b0, 8'h07, 6'd5, 2'd1, 2'b11, 2'd1, 8'hB2, 1'b1},  // R6 write fill stayed dirty
    '{1'b0, 8'hB2, 6'd6, 2'd3, 2'b01, 2'd0, 8'h00, 1'b0},  // R11 other set empty
    '{1'b0, 8'hE5, 6'd5, 2'd2, 2'b00, 2'd0, 8'h00, 1'b0}   // R11 set 5 intact
  };

  logic              clk = 1'b0;
  logic              rst;
  logic              req_valid;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr;
  logic              req_write;
  logic [WAY_W-1:0]  victim_way;
  logic              cmd_flush;
  logic              cmd_inval;
  logic              rsp_valid;
  logic [1:0]        rsp_code;
  logic [WAY_W-1:0]  rsp_way;
  logic [TAG_W-1:0]  rsp_old_tag;
  logic              touch_valid;
  logic [WAY_W-1:0]  touch_way;
  logic [SET_W-1:0]  touch_set;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  cache_tag_ctrl #(
    .SETS   (SETS),
    .WAYS   (WAYS),
    .ADDR_W (ADDR_W),
    .TAG_W  (TAG_W)
  ) uut (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_addr    (req_addr),
    .req_write   (req_write),
    .victim_way  (victim_way),
    .cmd_flush   (cmd_flush),
    .cmd_inval   (cmd_inval),
    .rsp_valid   (rsp_valid),
    .rsp_code    (rsp_code),
    .rsp_way     (rsp_way),
    .rsp_old_tag (rsp_old_tag),
    .touch_valid (touch_valid),
    .touch_way   (touch_way),
    .touch_set   (touch_set)
  );

  // R1: bench-side address builder: tag on top, set below, offset low
  function automatic logic [ADDR_W-1:0] make_addr(input logic [7:0] t, input logic [5:0] s,
                                                  input logic [OFF_W-1:0] off);
    logic [ADDR_W-1:0] a;
    a = '0;
    a[ADDR_W-1:ADDR_W-TAG_W] = TAG_W'(t);
    a[OFF_W +: SET_W] = s;
    a[OFF_W-1:0] = off;
    return a;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one request; checks the response cycle and the cycle after it
  task automatic access(input logic wr, input logic [7:0] t, input logic [5:0] s,
                        input logic [1:0] vic, input logic [1:0] code, input logic [1:0] way,
                        input logic [7:0] old, input logic chk_old, input logic [OFF_W-1:0] off);
    @(negedge clk);
    req_valid  = 1'b1;
    req_write  = wr;
    req_addr   = make_addr(t, s, off);
    victim_way = vic;
    @(negedge clk);
    req_valid = 1'b0;
    check("R2 rsp_valid", 64'(rsp_valid), 64'd1);
    check("R2 touch_valid", 64'(touch_valid), 64'd1);
    check("R3/R4/R5 rsp_code", 64'(rsp_code), 64'(code));
    check("R3/R4/R5 rsp_way", 64'(rsp_way), 64'(way));
    check("R2 touch_way", 64'(touch_way), 64'(way));
    check("R1 touch_set", 64'(touch_set), 64'(s));
    if (chk_old) check("R5 rsp_old_tag", 64'(rsp_old_tag), 64'(old));
    @(negedge clk);
    check("R2 strobe single cycle", 64'(rsp_valid), 64'd0);
  endtask

  task automatic pulse_cmd(input logic fl, input logic inv);
    @(negedge clk);
    cmd_flush = fl;
    cmd_inval = inv;
    req_valid = 1'b1;               // R9: competing request must be refused
    req_write = 1'b1;
    req_addr  = make_addr(8'h55, 6'd5, '0);
    #1;
    check("R9 ready low during command", 64'(req_ready), 64'd0);
    @(negedge clk);
    cmd_flush = 1'b0;
    cmd_inval = 1'b0;
    req_valid = 1'b0;
    check("R9 no response to refused request", 64'(rsp_valid), 64'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    victim_way = '0; cmd_flush = 1'b0; cmd_inval = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10 rsp_valid after reset", 64'(rsp_valid), 64'd0);
    check("R10 ready after reset", 64'(req_ready), 64'd1);

    // table walk; offset varies to show it is ignored (R1)
    for (int i = 0; i < NVEC; i++) begin
      access(TBL[i].wr, TBL[i].tag, TBL[i].set, TBL[i].vic, TBL[i].code,
             TBL[i].way, TBL[i].old, TBL[i].chk_old, OFF_W'(i * 5 + 1));
    end
    // set 5 now: w0 E5, w1 07, w2 F6, w3 D4, all clean

    // R7: make F6 dirty, flush, then evict it: clean and still resident
    access(1'b1, 8'hF6, 6'd5, 2'd0, 2'b00, 2'd2, 8'h00, 1'b0, '0);
    pulse_cmd(1'b1, 1'b0);
    access(1'b0, 8'h99, 6'd5, 2'd2, 2'b10, 2'd2, 8'hF6, 1'b1, '0);  // R7 clean, tag kept

    // R8: invalidate, then a former hit becomes a fill of way0, next of way1
    access(1'b1, 8'hD4, 6'd5, 2'd0, 2'b00, 2'd3, 8'h00, 1'b0, '0);
    pulse_cmd(1'b0, 1'b1);
    access(1'b0, 8'hD4, 6'd5, 2'd3, 2'b01, 2'd0, 8'h00, 1'b0, '0);  // R8
    access(1'b0, 8'h07, 6'd5, 2'd3, 2'b01, 2'd1, 8'h00, 1'b0, '0);  // R8

    // R10: reset mid-run empties the array
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R10 rsp_valid low after reset", 64'(rsp_valid), 64'd0);
    check("R10 ready high after reset", 64'(req_ready), 64'd1);
    access(1'b0, 8'hD4, 6'd5, 2'd3, 2'b01, 2'd0, 8'h00, 1'b0, '0);  // R10 miss

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule